// File: doc/BRIEF.md
# Two-Byte SPI Register Slave

This block is the serial front end of a host window made of two byte-wide registers. An external master drives four pins: an active-low select, a serial clock, a data line into the block and a data line out of it. Every access is one select period holding a header byte and then a data byte. The block turns that pair of bytes into one register access on a small parallel side. That side has a register-select bit, a one-cycle write strobe with its data, and a one-cycle read strobe whose returned value the block captures and sends back out.

The serial pins are not tied to the system clock. Each one passes through a two-flop synchronizer, and all edge detection and shifting happen in the system clock domain. The transfer is SPI mode 0 and MSB first. The block samples its input on a rising serial edge and updates its output after a falling one. The output pin has a separate enable, so the pad can float whenever the block is not returning read data.

A header whose six low bits are not all zero is rejected: the rest of that select period has no effect. Raising the select line in the middle of a transfer cancels it.

Top module: `spi_hw_slave`

## Requirements
- R1: The header's bit 7 sets `reg_sel` (1 selects the status register, 0 selects the data register). Its bit 6 sets the direction (1 = read, 0 = write). Both bytes are sent MSB first.
- R2: On a legal write, exactly one `reg_wr` pulse lasting one cycle follows the sixteenth rising serial edge. During that pulse `reg_wdata` holds the second byte and `reg_sel` holds header bit 7.
- R3: On a legal read, exactly one `reg_rd` pulse lasting one cycle follows the eighth rising edge. `reg_rdata` is captured on the next cycle. The captured byte is shifted out on `spi_miso` MSB first, one bit per data-phase clock. Each bit changes after a falling edge and is stable at the following rising edge.
- R4: A header whose bits 5..0 are not all zero causes no strobe. It leaves both registers unchanged and keeps `spi_miso_oe` low until the select line goes high.
- R5: `spi_miso_oe` is high only in the data phase of a legal read. It is low during the header, during writes, during rejected transfers and while the block is not selected.
- R6: If the select line goes high before the sixteenth bit of a write, or at any point in the header, no strobe is issued. The next select period decodes its header from bit 0.
- R7: Rising edges after the sixteenth in one select period are ignored. At most one strobe is issued per select period.
- R8: While reset is high and just after it, both strobes and `spi_miso_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; each serial clock phase lasts at least 4 cycles of it |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn | input | 1 | Slave select, active low |
| spi_sclk | input | 1 | Serial clock from the master, idle low |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| spi_miso_oe | output | 1 | Output enable for the `spi_miso` pad |
| reg_sel | output | 1 | Register select bit from the header |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_wdata | output | 8 | Write data, valid with `reg_wr` |
| reg_rdata | input | 8 | Register value; sampled the cycle after `reg_rd` |

## Verification
Legal writes and reads are swept over both registers with 32 data values spread across the byte range. The write-then-read pairs catch swapped select bits, reversed bit order, and shifting off by one bit. All 252 illegal headers (each top-bit pair with every nonzero low field) show whether any low bit is ignored by the check. Cancellations after every bit count from 0 to 15 and 24-bit select periods show whether the bit counter restarts when the select line goes high and stops at sixteen.

// File: rtl/spi_hw_pkg.sv
package spi_hw_pkg;

  // Phase of the current select period
  typedef enum logic [2:0] {
    PH_HDR  = 3'd0,   // collecting the header byte
    PH_WR   = 3'd1,   // legal write, collecting data byte
    PH_RD   = 3'd2,   // legal read, returning data byte
    PH_SKIP = 3'd3,   // rejected header, ignore until deselect
    PH_DONE = 3'd4    // both bytes seen, ignore extra clocks
  } spi_hw_phase_e;

endpackage

// File: rtl/spi_hw_sync.sv
module spi_hw_sync #(
  parameter int           WIDTH   = 3,
  parameter int           STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RST_VAL[g]}};
        else     chain_q <= {chain_q[STAGES-2:0], d_async[g]};
      end
      assign q_sync[g] = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/spi_hw_edge.sv
module spi_hw_edge (
  input  logic clk,
  input  logic rst,
  input  logic sclk_s,
  output logic rise,
  output logic fall
);

  logic sclk_d;

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  assign rise = sclk_s  & ~sclk_d;
  assign fall = ~sclk_s &  sclk_d;

endmodule

// File: rtl/spi_hw_rx.sv
module spi_hw_rx #(
  parameter int W  = 8,
  parameter int CW = $clog2(2*W+1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          csn_s,
  input  logic          rise,
  input  logic          mosi_s,
  output logic [CW-1:0] bit_cnt,
  output logic [W-1:0]  byte_now,
  output logic          bit_take
);

  localparam logic [CW-1:0] LAST = CW'(2*W);

  logic [W-2:0] sh_q;

  assign bit_take = rise & ~csn_s & (bit_cnt < LAST);
  assign byte_now = {sh_q, mosi_s};

  always_ff @(posedge clk) begin
    if (rst || csn_s) begin
      sh_q    <= '0;
      bit_cnt <= '0;
    end else if (bit_take) begin
      sh_q    <= byte_now[W-2:0];
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/spi_hw_ctrl.sv
module spi_hw_ctrl
  import spi_hw_pkg::*;
#(
  parameter int W  = 8,
  parameter int CW = $clog2(2*W+1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          csn_s,
  input  logic          fall,
  input  logic          bit_take,
  input  logic [CW-1:0] bit_cnt,
  input  logic [W-1:0]  byte_now,
  input  logic [W-1:0]  reg_rdata,
  output logic          reg_sel,
  output logic          reg_wr,
  output logic          reg_rd,
  output logic [W-1:0]  reg_wdata,
  output logic          miso_q,
  output logic          miso_oe
);

  localparam int SEL_BIT = W - 1;
  localparam int DIR_BIT = W - 2;
  localparam int IW      = $clog2(W);
  localparam logic [CW-1:0] HDR_LAST  = CW'(W - 1);
  localparam logic [CW-1:0] DATA_LAST = CW'(2*W - 1);
  localparam logic [CW-1:0] DATA_FIRST = CW'(W);

  spi_hw_phase_e phase_q;
  logic [W-1:0]  rdbuf_q;

  logic          hdr_done, data_done, hdr_legal;
  logic [IW-1:0] out_idx;

  assign hdr_done  = bit_take & (bit_cnt == HDR_LAST);
  assign data_done = bit_take & (bit_cnt == DATA_LAST);
  assign hdr_legal = (byte_now[W-3:0] == '0);
  assign out_idx   = IW'((2*W - 1) - int'(bit_cnt));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_HDR;
      reg_sel   <= 1'b0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
      reg_wdata <= '0;
      rdbuf_q   <= '0;
      miso_q    <= 1'b0;
      miso_oe   <= 1'b0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      if (reg_rd) rdbuf_q <= reg_rdata;

      if (csn_s) begin
        phase_q <= PH_HDR;
        miso_oe <= 1'b0;
        miso_q  <= 1'b0;
      end else begin
        if (hdr_done) begin
          if (hdr_legal) begin
            reg_sel <= byte_now[SEL_BIT];
            reg_rd  <= byte_now[DIR_BIT];
            phase_q <= byte_now[DIR_BIT] ? PH_RD : PH_WR;
          end else begin
            phase_q <= PH_SKIP;
          end
        end

        if (data_done) begin
          if (phase_q == PH_WR) begin
            reg_wdata <= byte_now;
            reg_wr    <= 1'b1;
          end
          if (phase_q != PH_SKIP) phase_q <= PH_DONE;
          miso_oe <= 1'b0;
        end else if (fall && phase_q == PH_RD && bit_cnt >= DATA_FIRST) begin
          miso_q  <= rdbuf_q[out_idx];
          miso_oe <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spi_hw_slave.sv
module spi_hw_slave #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         spi_csn,
  input  logic         spi_sclk,
  input  logic         spi_mosi,
  output logic         spi_miso,
  output logic         spi_miso_oe,
  output logic         reg_sel,
  output logic         reg_wr,
  output logic         reg_rd,
  output logic [W-1:0] reg_wdata,
  input  logic [W-1:0] reg_rdata
);

  localparam int CW = $clog2(2*W+1);

  logic [2:0]    pins_s;
  logic          csn_s, sclk_s, mosi_s;
  logic          rise, fall, bit_take;
  logic [CW-1:0] bit_cnt;
  logic [W-1:0]  byte_now;

  spi_hw_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async ({spi_csn, spi_sclk, spi_mosi}),
    .q_sync  (pins_s)
  );

  assign csn_s  = pins_s[2];
  assign sclk_s = pins_s[1];
  assign mosi_s = pins_s[0];

  spi_hw_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .sclk_s (sclk_s),
    .rise   (rise),
    .fall   (fall)
  );

  spi_hw_rx #(.W(W), .CW(CW)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .csn_s    (csn_s),
    .rise     (rise),
    .mosi_s   (mosi_s),
    .bit_cnt  (bit_cnt),
    .byte_now (byte_now),
    .bit_take (bit_take)
  );

  spi_hw_ctrl #(.W(W), .CW(CW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .csn_s     (csn_s),
    .fall      (fall),
    .bit_take  (bit_take),
    .bit_cnt   (bit_cnt),
    .byte_now  (byte_now),
    .reg_rdata (reg_rdata),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .miso_q    (spi_miso),
    .miso_oe   (spi_miso_oe)
  );

endmodule

// File: rtl/spi_hw_chk.sv
module spi_hw_chk (
  input logic clk,
  input logic rst,
  input logic csn_s,
  input logic reg_wr,
  input logic reg_rd,
  input logic miso_oe
);

  logic       rd_armed;
  logic [1:0] n_strobe;

  always_ff @(posedge clk) begin
    if (rst || csn_s) begin
      rd_armed <= 1'b0;
      n_strobe <= 2'd0;
    end else begin
      if (reg_rd) rd_armed <= 1'b1;
      if ((reg_wr || reg_rd) && n_strobe != 2'd3) n_strobe <= n_strobe + 2'd1;
    end
  end

  // R5: output enable only after a read strobe in this select period
  a_r5_oe_after_read: assert property (@(posedge clk) disable iff (rst)
    miso_oe |-> rd_armed);

  // R7: at most one strobe per select period
  a_r7_single_strobe: assert property (@(posedge clk) disable iff (rst)
    (reg_wr || reg_rd) |-> (n_strobe == 2'd0));

  // R6: no strobe while deselected
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (csn_s && $past(csn_s)) |-> (!reg_wr && !reg_rd));

  // R2: write strobe lasts one cycle
  a_r2_wr_pulse: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> !reg_wr);

  // R3: read strobe lasts one cycle
  a_r3_rd_pulse: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> !reg_rd);

  // R2 R3: a direction is never both
  a_r2_excl: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_rd));

endmodule

bind spi_hw_slave spi_hw_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .csn_s   (csn_s),
  .reg_wr  (reg_wr),
  .reg_rd  (reg_rd),
  .miso_oe (spi_miso_oe)
);

// File: tb/spi_hw_slave_tb.sv
`timescale 1ns/1ps
module spi_hw_slave_tb_top;

  localparam int HALF = 4;  // system clocks per serial clock phase

  logic       clk = 1'b0;
  logic       rst;
  logic       spi_csn, spi_sclk, spi_mosi;
  logic       spi_miso, spi_miso_oe;
  logic       reg_sel, reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;

  logic [7:0] reg_a, reg_b;   // sel 0 and sel 1 responder registers
  int         wr_n, rd_n, oe_bad;
  bit         oe_allow;
  int         tests, failed;

  always #5 clk = ~clk;

  spi_hw_slave dut_i (
    .clk         (clk),
    .rst         (rst),
    .spi_csn     (spi_csn),
    .spi_sclk    (spi_sclk),
    .spi_mosi    (spi_mosi),
    .spi_miso    (spi_miso),
    .spi_miso_oe (spi_miso_oe),
    .reg_sel     (reg_sel),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata)
  );

  // simple two-register responder
  assign reg_rdata = reg_sel ? reg_b : reg_a;

  always @(posedge clk) begin
    if (rst) begin
      reg_a <= 8'h00; reg_b <= 8'h00; wr_n <= 0; rd_n <= 0;
    end else begin
      if (reg_wr) begin
        wr_n <= wr_n + 1;
        if (reg_sel) reg_b <= reg_wdata; else reg_a <= reg_wdata;
      end
      if (reg_rd) rd_n <= rd_n + 1;
    end
  end

  always @(negedge clk) if (!rst && spi_miso_oe && !oe_allow) oe_bad <= oe_bad + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Mode 0, MSB first: vec[23] goes out first
  task automatic xfer(input logic [23:0] vec, input int nbits, input bit is_rd,
                      output logic [23:0] cap, output logic [23:0] oec);
    cap = '0; oec = '0;
    @(negedge clk) spi_csn = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = vec[23-i];
      repeat (HALF) @(negedge clk);
      cap[23-i] = spi_miso;
      oec[23-i] = spi_miso_oe;
      spi_sclk = 1'b1;
      if (is_rd && i == 7) oe_allow = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    spi_csn = 1'b1;
    repeat (8) @(negedge clk);
    oe_allow = 1'b0;
    spi_mosi = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failed++; tests++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    logic [23:0] cap, oec;
    logic [7:0]  d, hdr;
    int w0, r0;
    tests = 0; failed = 0; oe_bad = 0; oe_allow = 1'b0;
    rst = 1'b1; spi_csn = 1'b1; spi_sclk = 1'b0; spi_mosi = 1'b0;
    repeat (5) @(negedge clk);
    chk(!reg_wr && !reg_rd && !spi_miso_oe, "R8 reset outputs", {reg_wr, reg_rd, spi_miso_oe}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!reg_wr && !reg_rd && !spi_miso_oe, "R8 after reset", {reg_wr, reg_rd, spi_miso_oe}, 0);

    // legal write/read sweep over both registers
    for (int i = 0; i < 32; i++) begin
      for (int s = 0; s < 2; s++) begin
        d = 8'((i * 37 + 5) & 255);
        hdr = {s[0], 1'b0, 6'b0};
        w0 = wr_n; r0 = rd_n;
        xfer({hdr, d, 8'h00}, 16, 1'b0, cap, oec);
        chk(wr_n == w0 + 1 && rd_n == r0, "R2 one write strobe", wr_n - w0, 1);
        chk((s ? reg_b : reg_a) == d, "R1 write routed by select bit", s ? reg_b : reg_a, d);
        hdr = {s[0], 1'b1, 6'b0};
        w0 = wr_n; r0 = rd_n;
        xfer({hdr, 8'h00, 8'h00}, 16, 1'b1, cap, oec);
        chk(rd_n == r0 + 1 && wr_n == w0, "R3 one read strobe", rd_n - r0, 1);
        chk(cap[15:8] == d, "R3 read data MSB first", cap[15:8], d);
        chk(oec[15:8] == 8'hFF && oec[23:16] == 8'h00, "R5 enable in read data phase only",
            oec[23:8], 16'h00FF);
      end
    end

    // every illegal header
    for (int t = 0; t < 4; t++) begin
      for (int lo = 1; lo < 64; lo++) begin
        w0 = wr_n; r0 = rd_n;
        hdr = {t[1:0], lo[5:0]};
        xfer({hdr, 8'hC3, 8'h00}, 16, 1'b0, cap, oec);
        chk(wr_n == w0 && rd_n == r0, "R4 illegal header no strobe", (wr_n - w0) + (rd_n - r0), 0);
      end
    end
    d = reg_a;
    xfer({8'h40, 8'h00, 8'h00}, 16, 1'b1, cap, oec);
    chk(cap[15:8] == d && d != 8'hC3, "R4 data register unchanged", cap[15:8], d);
    d = reg_b;
    xfer({8'hC0, 8'h00, 8'h00}, 16, 1'b1, cap, oec);
    chk(cap[15:8] == d && d != 8'hC3, "R4 status register unchanged", cap[15:8], d);

    // cancellation after 0..15 bits of a write
    for (int k = 0; k < 16; k++) begin
      w0 = wr_n;
      xfer({8'h80, 8'h3C, 8'h00}, k, 1'b0, cap, oec);
      chk(wr_n == w0, "R6 cancelled write no strobe", wr_n - w0, 0);
      xfer({8'h80, 8'h99 ^ 8'(k), 8'h00}, 16, 1'b0, cap, oec);
      chk(reg_b == (8'h99 ^ 8'(k)), "R6 next transfer decodes from bit 0", reg_b, 8'h99 ^ 8'(k));
    end

    // extra clocks beyond sixteen
    w0 = wr_n;
    xfer({8'h00, 8'h6E, 8'hFF}, 24, 1'b0, cap, oec);
    chk(wr_n == w0 + 1, "R7 one strobe with extra clocks", wr_n - w0, 1);
    chk(reg_a == 8'h6E, "R7 extra bits do not alter data", reg_a, 8'h6E);
    r0 = rd_n;
    xfer({8'h40, 8'h00, 8'h00}, 24, 1'b1, cap, oec);
    chk(rd_n == r0 + 1, "R7 one read strobe with extra clocks", rd_n - r0, 1);
    chk(cap[15:8] == 8'h6E, "R3 read with extra clocks", cap[15:8], 8'h6E);

    chk(oe_bad == 0, "R5 R4 no enable outside read data phase", oe_bad, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

endmodule